// File: doc/BRIEF.md
# Reference Clock Presence Monitor

This block watches one of two reference clocks and reports whether the chosen one is present and running near its expected rate. Each reference reaches the block as a toggle signal: a divider outside the block flips it once every `PRESCALE` reference cycles. The block brings that signal into the system clock domain and counts its transitions over a fixed gate window of `GATE_CYC` system clock cycles. It then compares the total with a pass band around the expected count.

The expected count depends on a two-bit rate code and a forward-error-correction (FEC) flag. The code can name a rate of 19.44, 77.76 or 155.52 MHz. Under FEC, each of these is replaced by a faster rate: 20.829, 83.314 or 166.629 MHz. The pass band is ±25 % of the expected count, rounded outward, and it is fixed when the design is elaborated. The block outputs a no-reference flag and the edge total of the last complete window. The loop that consumes the reference clock uses the flag to decide whether the reference can be trusted.

Top module: `refclk_watch`

## Requirements
- R1: `ref_pick` = 0 measures `ref0_tgl` and `ref_pick` = 1 measures `ref1_tgl`; the other input has no effect on either output.
- R2: Rate codes 00, 10 and 11 stand for 19.44, 77.76 and 155.52 MHz. The expected count is f·GATE_CYC/(SYS_KHZ·PRESCALE). The pass band runs from floor(0.75·expected), but never below 1, up to ceil(1.25·expected).
- R3: With `fec_mode` = 1, the rates for codes 00, 10 and 11 become 20.829, 83.314 and 166.629 MHz.
- R4: A selected reference with no transitions during a window gives `no_ref` = 1 at the end of that window.
- R5: At the end of a window, `no_ref` becomes 0 when the edge total is inside the pass band and 1 when it is outside.
- R6: Rate code 01 is illegal and sets `no_ref` to 1 at the end of every window.
- R7: A window lasts `GATE_CYC` system clock cycles. `no_ref` and `edge_count` change only at the end of a window, and `edge_count` then shows that window's edge total.
- R8: A change of `ref_pick`, `rate_code` or `fec_mode` throws away the window in progress; the outputs keep their values until a full window under the new setting has ended.
- R9: During reset and until the first complete window, `no_ref` = 1 and `edge_count` = 0.
- R10: Each toggle input passes through a two-flop synchronizer, and every rising or falling transition of the selected input counts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Trusted system clock used for the gate window |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref0_tgl | input | 1 | Toggle signal from reference 0 (asynchronous) |
| ref1_tgl | input | 1 | Toggle signal from reference 1 (asynchronous) |
| ref_pick | input | 1 | Reference select: 0 selects reference 0, 1 selects reference 1 |
| rate_code | input | 2 | Expected-rate code: 00, 10 or 11; 01 is illegal |
| fec_mode | input | 1 | Selects the FEC variant of each rate |
| no_ref | output | 1 | High when the reference is missing, off frequency, or the rate code is illegal |
| edge_count | output | $clog2(GATE_CYC+1) | Edge total of the last complete window |

## Verification
The checker bound to the top module watches several rules on every cycle. Both outputs must hold still except at the end of a window. `no_ref` must stay high, and the count must stay zero, until the first window has ended. An illegal rate code must always produce the flag. Other behaviour can only be shown by the bench's scenarios, because it depends on how fast the stimulus toggles: the pass band edges for each rate with and without FEC, a stopped reference, which input the select actually measures, and the discarding of a window when the setting changes part way through it.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

   localparam int NUM_CODES = 4;

   // Reference rate in kHz for a code and FEC flag; 0 marks the illegal code.
   function automatic longint rate_khz(input int code, input bit fec);
      case (code)
         0:       return fec ? 64'd20829  : 64'd19440;
         2:       return fec ? 64'd83314  : 64'd77760;
         3:       return fec ? 64'd166629 : 64'd155520;
         default: return 64'd0;
      endcase
   endfunction

   function automatic longint band_lo(input int code, input bit fec,
                                      input longint sys_khz, input longint prescale,
                                      input longint gate);
      longint num, den, v;
      num = rate_khz(code, fec) * gate;
      den = 4 * sys_khz * prescale;
      v   = (3 * num) / den;
      if (v < 1) v = 1;
      return v;
   endfunction

   function automatic longint band_hi(input int code, input bit fec,
                                      input longint sys_khz, input longint prescale,
                                      input longint gate);
      longint num, den;
      num = rate_khz(code, fec) * gate;
      den = 4 * sys_khz * prescale;
      return (5 * num + den - 1) / den;
   endfunction

endpackage

// File: rtl/refmon_sync_edge.sv
module refmon_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic edge_pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("refmon_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-1:0], tgl_in};
   end

   assign edge_pulse = sr[STAGES] ^ sr[STAGES-1];
endmodule

// File: rtl/refmon_gate.sv
module refmon_gate #(
   parameter int GATE_CYC = 4096,
   parameter int CNT_W    = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_in,
   input  logic             restart,
   output logic             done,
   output logic [CNT_W-1:0] total
);
   localparam int GW = (GATE_CYC > 1) ? $clog2(GATE_CYC) : 1;
   localparam logic [GW-1:0] LAST = GW'(GATE_CYC - 1);

   logic [GW-1:0]    gate_q;
   logic [CNT_W-1:0] cnt_q;

   assign done  = (gate_q == LAST) && !restart;
   assign total = cnt_q + CNT_W'(edge_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= '0;
         cnt_q  <= '0;
      end else if (restart || done) begin
         gate_q <= '0;
         cnt_q  <= '0;
      end else begin
         gate_q <= gate_q + 1'b1;
         cnt_q  <= total;
      end
   end
endmodule

// File: rtl/refmon_judge.sv
module refmon_judge
   import refmon_pkg::*;
#(
   parameter int SYS_KHZ  = 100000,
   parameter int PRESCALE = 16,
   parameter int GATE_CYC = 4096,
   parameter int CNT_W    = 13
) (
   input  logic [1:0]       rate_code,
   input  logic             fec_mode,
   input  logic [CNT_W-1:0] count,
   output logic             bad
);
   localparam int ENTRIES = 2 * NUM_CODES;

   logic [CNT_W-1:0] lo_tab [ENTRIES];
   logic [CNT_W-1:0] hi_tab [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_band
      localparam int  CODE = g % NUM_CODES;
      localparam bit  FEC  = (g / NUM_CODES) != 0;
      localparam longint LO = band_lo(CODE, FEC, SYS_KHZ, PRESCALE, GATE_CYC);
      localparam longint HI = band_hi(CODE, FEC, SYS_KHZ, PRESCALE, GATE_CYC);
      if (CODE != 1 && HI > GATE_CYC / 2) begin : g_fast
         $error("refmon_judge: expected count too high to sample for code %0d", CODE);
      end
      assign lo_tab[g] = CNT_W'(LO);
      assign hi_tab[g] = CNT_W'(HI);
   end

   logic [$clog2(ENTRIES)-1:0] idx;
   logic legal;

   always_comb begin
      idx   = {fec_mode, rate_code};
      legal = (rate_code != 2'b01);
      bad   = !legal || (count < lo_tab[idx]) || (count > hi_tab[idx]);
   end
endmodule

// File: rtl/refclk_watch.sv
module refclk_watch #(
   parameter int SYS_KHZ     = 100000,
   parameter int PRESCALE    = 16,
   parameter int GATE_CYC    = 4096,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(GATE_CYC + 1)
) (
   input  logic             clk_sys,
   input  logic             rst_n,
   input  logic             ref0_tgl,
   input  logic             ref1_tgl,
   input  logic             ref_pick,
   input  logic [1:0]       rate_code,
   input  logic             fec_mode,
   output logic             no_ref,
   output logic [CNT_W-1:0] edge_count
);
   localparam int LANES = 2;

   if (GATE_CYC < 2) begin : g_bad_gate
      $error("refclk_watch: GATE_CYC must be at least 2");
   end
   if (SYS_KHZ < 1 || PRESCALE < 1) begin : g_bad_rate
      $error("refclk_watch: SYS_KHZ and PRESCALE must be positive");
   end

   logic [LANES-1:0] ref_vec;
   logic [LANES-1:0] lane_edge;

   assign ref_vec = {ref1_tgl, ref0_tgl};

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      refmon_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
         .clk        (clk_sys),
         .rst_n      (rst_n),
         .tgl_in     (ref_vec[l]),
         .edge_pulse (lane_edge[l])
      );
   end

   // Configuration tracking: any change restarts the window.
   logic [3:0] cfg_now, cfg_q;
   logic       cfg_change;

   assign cfg_now    = {ref_pick, rate_code, fec_mode};
   assign cfg_change = (cfg_now != cfg_q);

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_now;
   end

   logic             win_done;
   logic [CNT_W-1:0] win_total;
   logic             win_bad;

   refmon_gate #(.GATE_CYC(GATE_CYC), .CNT_W(CNT_W)) u_gate (
      .clk     (clk_sys),
      .rst_n   (rst_n),
      .edge_in (lane_edge[ref_pick]),
      .restart (cfg_change),
      .done    (win_done),
      .total   (win_total)
   );

   refmon_judge #(
      .SYS_KHZ  (SYS_KHZ),
      .PRESCALE (PRESCALE),
      .GATE_CYC (GATE_CYC),
      .CNT_W    (CNT_W)
   ) u_judge (
      .rate_code (rate_code),
      .fec_mode  (fec_mode),
      .count     (win_total),
      .bad       (win_bad)
   );

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         no_ref     <= 1'b1;
         edge_count <= '0;
      end else if (win_done) begin
         no_ref     <= win_bad;
         edge_count <= win_total;
      end
   end
endmodule

// File: rtl/refclk_watch_chk.sv
module refclk_watch_chk #(
   parameter int GATE_CYC = 4096,
   parameter int CNT_W    = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       rate_code,
   input logic             done,
   input logic             no_ref,
   input logic [CNT_W-1:0] edge_count
);
   logic seen_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    seen_done <= 1'b0;
      else if (done) seen_done <= 1'b1;
   end

   a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(no_ref));

   a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(edge_count));

   a_r6_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rate_code == 2'b01) |=> no_ref);

   a_r9_flag_startup: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_done |-> no_ref);

   a_r9_count_startup: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_done |-> (edge_count == '0));

   a_r10_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      32'(edge_count) <= GATE_CYC);
endmodule

bind refclk_watch refclk_watch_chk #(.GATE_CYC(GATE_CYC), .CNT_W(CNT_W)) u_chk (
   .clk        (clk_sys),
   .rst_n      (rst_n),
   .rate_code  (rate_code),
   .done       (win_done),
   .no_ref     (no_ref),
   .edge_count (edge_count)
);

// File: tb/tb_refclk_watch.sv
module tb_refclk_watch;
   localparam int CLK_PERIOD = 10;
   localparam int SYS_KHZ    = 100000;
   localparam int PRESCALE   = 16;
   localparam int GATE       = 1024;
   localparam int CW         = $clog2(GATE + 1);
   localparam int NVEC       = 15;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          tga = 0, tgb = 0;
   logic          pick = 0;
   logic [1:0]    code = 2'b11;
   logic          fec = 0;
   logic          no_ref;
   logic [CW-1:0] edge_count;
   int            pa = 10, pb = 0;
   int            n_checks = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refclk_watch #(.SYS_KHZ(SYS_KHZ), .PRESCALE(PRESCALE), .GATE_CYC(GATE)) dut (
      .clk_sys (clk), .rst_n (rst_n), .ref0_tgl (tga), .ref1_tgl (tgb),
      .ref_pick (pick), .rate_code (code), .fec_mode (fec),
      .no_ref (no_ref), .edge_count (edge_count)
   );

   // Toggle generators: one transition every pa / pb system cycles, stopped at 0.
   initial forever begin
      if (pa == 0) @(posedge clk);
      else begin repeat (pa) @(posedge clk); #1 tga = ~tga; end
   end
   initial forever begin
      if (pb == 0) @(posedge clk);
      else begin repeat (pb) @(posedge clk); #1 tgb = ~tgb; end
   end

   // {pick, code, fec, pa, pb, expected no_ref}
   localparam logic [20:0] VEC [NVEC] = '{
      {1'b0, 2'b11, 1'b0, 8'd10, 8'd0,  1'b0},  // R1 ref0, 155.52 band [74,125], ~102
      {1'b1, 2'b11, 1'b0, 8'd10, 8'd0,  1'b1},  // R4 ref1 stopped while ref0 runs
      {1'b1, 2'b11, 1'b0, 8'd0,  8'd10, 1'b0},  // R1 ref1 good, ref0 stopped
      {1'b1, 2'b11, 1'b0, 8'd10, 8'd30, 1'b1},  // R1 ref1 slow (~34), good ref0 ignored
      {1'b0, 2'b10, 1'b0, 8'd20, 8'd0,  1'b0},  // R2 77.76 band [37,63], ~51
      {1'b0, 2'b10, 1'b0, 8'd30, 8'd0,  1'b1},  // R5 ~34 below band
      {1'b0, 2'b10, 1'b0, 8'd14, 8'd0,  1'b1},  // R5 ~73 above band
      {1'b0, 2'b00, 1'b0, 8'd80, 8'd0,  1'b0},  // R2 19.44 band [9,16], ~12.8
      {1'b0, 2'b01, 1'b0, 8'd80, 8'd0,  1'b1},  // R6 illegal code
      {1'b0, 2'b11, 1'b1, 8'd9,  8'd0,  1'b0},  // R3 166.629 band [79,134], ~113
      {1'b0, 2'b11, 1'b0, 8'd8,  8'd0,  1'b1},  // R5 ~128 above 125
      {1'b0, 2'b11, 1'b1, 8'd8,  8'd0,  1'b0},  // R3 ~128 inside FEC band
      {1'b0, 2'b10, 1'b1, 8'd17, 8'd0,  1'b0},  // R3 83.314 band [39,67], ~60
      {1'b0, 2'b00, 1'b1, 8'd65, 8'd0,  1'b0},  // R3 20.829 band [9,17], ~15.75
      {1'b0, 2'b00, 1'b0, 8'd60, 8'd0,  1'b1}   // R5 ~17 above 16
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_count(input string req, input int exp, input int tol);
      int d;
      d = int'(edge_count) - exp;
      check(d <= tol && d >= -tol, req, "edge_count", int'(edge_count), exp);
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      // Directed: reset state and first window (R9)
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(no_ref == 1'b1, "R9", "no_ref in reset", no_ref, 1);
      check(edge_count == 0, "R9", "edge_count in reset", edge_count, 0);
      rst_n = 1;
      cycles(5);
      check(no_ref == 1'b1, "R9", "no_ref after release", no_ref, 1);
      cycles(995);
      check(no_ref == 1'b1, "R9", "no_ref before first window", no_ref, 1);
      check(edge_count == 0, "R9", "edge_count before first window", edge_count, 0);
      cycles(50);
      check(no_ref == 1'b0, "R7", "no_ref after first window", no_ref, 0);
      check_count("R10", GATE / 10, 3);
      // Discard on configuration change (R8): change at ~1524, old end ~2048
      cycles(474);
      code = 2'b10;
      cycles(576);
      check(no_ref == 1'b0, "R8", "no_ref after discarded window", no_ref, 0);
      cycles(500);
      check(no_ref == 1'b1, "R8", "no_ref after full new window", no_ref, 1);

      // Table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [20:0] v;
         int psel, expc;
         v    = VEC[i];
         pick = v[20];
         code = v[19:18];
         fec  = v[17];
         pa   = int'(v[16:9]);
         pb   = int'(v[8:1]);
         psel = pick ? pb : pa;
         expc = (psel == 0) ? 0 : GATE / psel;
         cycles(3 * GATE);
         check(no_ref == v[0], "R5", $sformatf("no_ref vector %0d", i), no_ref, v[0]);
         check_count("R7", expc, 2);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule